// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It divides a fast input clock by N = B·P + A. A prescaler divides by either P or P+1 on each of its periods. A swallow count A and a main count B decide which of the two it uses. The divided result is one single-cycle pulse per division cycle, which is meant to drive a phase detector directly.

The swallow count holds the prescaler at P+1 for the first A prescaler periods of a cycle. The prescaler then falls back to P for the rest of the B periods. Both counts, and the prescaler choice, reload only when a division cycle ends, so settings can be changed at any time without making a short or long cycle.

A registered flag reports whether the current settings give a legal, contiguous division ratio. The modulus control line is also brought out, so the swallow phase of each cycle can be observed.

Top module: `psd_divider`

## Requirements
- R1: With legal settings, `div_out` pulses once every B·P + A clock cycles, and each pulse is high for exactly one cycle.
- R2: `mode_sel` selects the prescaler pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33 and 3 gives 64/65.
- R3: Reset is synchronous and active high. `div_out` stays low while reset is held. The first pulse appears exactly N clocks after the last clock edge that samples reset high, using the settings that were present during reset.
- R4: The swallow value works at both ends of its range. A = 0 gives a period of B·P, and A = 63 gives B·P + 63.
- R5: The main value works at both ends of its range: B = 3 and B = 8191.
- R6: A change to `mode_sel`, `a_val` or `b_val` in the middle of a division cycle leaves that cycle's length unchanged. The new settings set the length of the following cycle.
- R7: `mod_ctl` is high for the first A prescaler periods of each cycle, which is A·(P+1) clocks starting in the cycle where `div_out` is high. It is low for the rest of the cycle, and it is never high when A = 0.
- R8: One clock after the settings are applied, `cfg_ok` is high exactly when B ≥ 3, A ≤ B and B·P + A ≥ P² − P. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Prescaler pair select (0: 8/9, 1: 16/17, 2: 32/33, 3: 64/65) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per division cycle |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| cfg_ok | output | 1 | Registered flag that the settings are legal |

## Verification
Every prescaler pair is run with the same non-zero swallow and main values. A period mismatch there points to the modulus decode, not to the counts.

Settings with A = 0, A = B = 63, B = 3 and B = 8191 check the swallow counter's stop condition and the main counter's terminal detection at their edges. The width of the `mod_ctl` high run separates an error in the swallow count from an error in the prescaler length.

A mid-cycle settings change tells apart a design that reloads only at the boundary from one that picks up new values early. A set of legal and illegal settings placed just on each side of the P² − P bound, the B ≥ 3 limit and the A ≤ B limit exercises each term of `cfg_ok` on its own.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;
  typedef logic [MODE_W-1:0] psd_mode_t;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: one period lasts p_val clocks, or p_val+1 when plus is set.
module psd_prescaler #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] p_val,
  input  logic          plus,
  output logic [CW-1:0] cnt,
  output logic          tc
);
  logic [CW-1:0] lim;

  assign lim = plus ? p_val : (p_val - CW'(1));
  assign tc  = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || tc) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/psd_swallow.sv
// Swallow (A) and main (B) counters; both step once per prescaler period.
module psd_swallow #(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tc,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          mod_hi,
  output logic          cyc_end
);
  logic [AW-1:0] a_rem;
  logic [BW-1:0] b_rem;
  logic          last;

  assign last    = (b_rem <= BW'(1));
  assign cyc_end = tc && last;
  assign mod_hi  = (a_rem != '0);

  always_ff @(posedge clk) begin
    if (rst || cyc_end) begin
      a_rem <= a_val;
      b_rem <= b_val;
    end else if (tc) begin
      b_rem <= b_rem - BW'(1);
      if (mod_hi) a_rem <= a_rem - AW'(1);
    end
  end
endmodule

// File: rtl/psd_cfg_check.sv
// Combinational legality test of a settings triple.
module psd_cfg_check
  import psd_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 13,
  parameter int PL = 3
) (
  input  psd_mode_t     mode,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic          ok
);
  localparam int NW_A = BW + PL + 4;
  localparam int NW_B = 2 * PL + 8;
  localparam int NW   = (NW_A > NW_B) ? NW_A : NW_B;

  logic [NW-1:0] p_tab [NUM_MODES];
  logic [NW-1:0] p, n, floor_n;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_ptab
    assign p_tab[m] = NW'(1) << (PL + m);
  end

  assign p       = p_tab[mode];
  assign n       = NW'(b) * p + NW'(a);
  assign floor_n = p * p - p;
  assign ok      = (b >= BW'(3)) && (NW'(a) <= NW'(b)) && (n >= floor_n);
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int AW          = 6,
  parameter int BW          = 13,
  parameter int P_BASE_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          div_out,
  output logic          mod_ctl,
  output logic          cfg_ok
);
  localparam int P_MAX = 1 << (P_BASE_LOG2 + MODE_W + 1);
  localparam int CW    = $clog2(P_MAX + 1);

  psd_mode_t     mode_q;
  logic [CW-1:0] p_val;
  logic [CW-1:0] pre_cnt;
  logic          pre_tc;
  logic          cyc_end;
  logic          mod_hi;
  logic          ok_c;

  // prescaler choice is held for the whole division cycle
  always_ff @(posedge clk) begin
    if (rst || cyc_end) mode_q <= psd_mode_t'(mode_sel);
  end

  assign p_val = CW'(1) << (P_BASE_LOG2 + int'(mode_q));

  psd_prescaler #(.CW(CW)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .p_val (p_val),
    .plus  (mod_hi),
    .cnt   (pre_cnt),
    .tc    (pre_tc)
  );

  psd_swallow #(.AW(AW), .BW(BW)) u_swl (
    .clk     (clk),
    .rst     (rst),
    .tc      (pre_tc),
    .a_val   (a_val),
    .b_val   (b_val),
    .mod_hi  (mod_hi),
    .cyc_end (cyc_end)
  );

  psd_cfg_check #(.AW(AW), .BW(BW), .PL(P_BASE_LOG2)) u_chkcfg (
    .mode (psd_mode_t'(mode_sel)),
    .a    (a_val),
    .b    (b_val),
    .ok   (ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out <= 1'b0;
      cfg_ok  <= 1'b0;
    end else begin
      div_out <= cyc_end;
      cfg_ok  <= ok_c;
    end
  end

  assign mod_ctl = mod_hi;
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int AW = 6,
  parameter int BW = 13,
  parameter int PL = 3,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode_sel,
  input logic [AW-1:0] a_val,
  input logic [BW-1:0] b_val,
  input logic          div_out,
  input logic          mod_ctl,
  input logic          cyc_end,
  input logic [CW-1:0] pre_cnt,
  input logic [1:0]    mode_q
);
  localparam int NW = BW + PL + 4;

  logic [NW-1:0] n_in, n_next, n_run, cnt;
  logic          legal_in, legal_next, legal_run, seen, past_ok;

  assign n_in     = NW'(b_val) * (NW'(1) << (PL + int'(mode_sel))) + NW'(a_val);
  assign legal_in = (b_val != '0) && (BW'(a_val) <= b_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_next     <= n_in;
      legal_next <= legal_in;
      n_run      <= '0;
      legal_run  <= 1'b0;
      seen       <= 1'b0;
      cnt        <= '0;
      past_ok    <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (cyc_end) begin
        n_next     <= n_in;
        legal_next <= legal_in;
      end
      if (div_out) begin
        n_run     <= n_next;
        legal_run <= legal_next;
        seen      <= 1'b1;
        cnt       <= NW'(1);
      end else begin
        cnt <= cnt + NW'(1);
      end
    end
  end

  // R1: spacing between pulses equals the ratio captured at the boundary
  a_r1_period: assert property (@(posedge clk) disable iff (rst)
    (div_out && seen && legal_run) |-> (cnt == n_run));

  // R1: pulse lasts one cycle
  a_r1_single: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R2: prescaler count never passes its P+1 length
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= (CW'(1) << (PL + int'(mode_q))));

  // R6: prescaler choice changes only at a cycle boundary
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !div_out) |-> $stable(mode_q));

  // R7: modulus control does not change inside a prescaler period
  a_r7_mod_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && pre_cnt != '0) |-> $stable(mod_ctl));
endmodule

bind psd_divider psd_divider_chk #(
  .AW(AW), .BW(BW), .PL(P_BASE_LOG2), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .a_val    (a_val),
  .b_val    (b_val),
  .div_out  (div_out),
  .mod_ctl  (mod_ctl),
  .cyc_end  (cyc_end),
  .pre_cnt  (pre_cnt),
  .mode_q   (mode_q)
);

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int BW = 13;
  localparam int LIMIT = 700000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'd0;
  logic [AW-1:0] a_val = '0;
  logic [BW-1:0] b_val = BW'(10);
  logic          div_out, mod_ctl, cfg_ok;
  int            errors = 0;
  int            checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psd_divider #(.AW(AW), .BW(BW), .P_BASE_LOG2(3)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .a_val(a_val), .b_val(b_val),
    .div_out(div_out), .mod_ctl(mod_ctl), .cfg_ok(cfg_ok)
  );

  function automatic int n_of(int m, int a, int b);
    return b * (8 << m) + a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int m, int a, int b);
    mode_sel = 2'(m);
    a_val    = AW'(a);
    b_val    = BW'(b);
  endtask

  // counts falling edges until div_out is seen high
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_out && n < LIMIT);
  endtask

  // R3: reset, then first pulse N clocks later
  task automatic start(int m, int a, int b, string req);
    int n;
    @(negedge clk);
    set_cfg(m, a, b);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(div_out == 1'b0, "R3 low in reset", int'(div_out), 0);
    end
    rst = 1'b0;
    wait_pulse(n);
    check(n == n_of(m, a, b), req, n, n_of(m, a, b));
  endtask

  task automatic t_modes();
    int n;
    for (int m = 0; m < 4; m++) begin
      start(m, 5, 12, "R3 first pulse");
      @(negedge clk);
      check(div_out == 1'b0, "R1 one-cycle pulse", int'(div_out), 0);
      wait_pulse(n);
      check(n + 1 == n_of(m, 5, 12), "R2 mode period", n + 1, n_of(m, 5, 12));
      wait_pulse(n);
      check(n == n_of(m, 5, 12), "R1 steady period", n, n_of(m, 5, 12));
    end
  endtask

  task automatic t_a_edges();
    int n;
    start(1, 0, 10, "R4 A=0 first");
    wait_pulse(n);
    check(n == 160, "R4 A=0 period", n, 160);
    start(0, 63, 63, "R4 A=B=63 first");
    wait_pulse(n);
    check(n == 567, "R4 A=63 period", n, 567);
    start(3, 63, 100, "R4 A=63 P=64 first");
  endtask

  task automatic t_b_edges();
    int n;
    start(0, 0, 3, "R5 B=3 first");
    wait_pulse(n);
    check(n == 24, "R5 B=3 period", n, 24);
    start(0, 63, 8191, "R5 B=8191 first");
  endtask

  task automatic t_swallow();
    int hi, tot;
    bit bad;
    start(0, 4, 10, "R7 setup");
    check(mod_ctl == 1'b1, "R7 high at pulse", int'(mod_ctl), 1);
    hi = 1;
    forever begin
      @(negedge clk);
      if (!mod_ctl) break;
      hi++;
    end
    check(hi == 36, "R7 high run", hi, 36);
    tot = hi + 1;
    bad = 1'b0;
    while (!div_out && tot < LIMIT) begin
      @(negedge clk);
      if (!div_out) begin
        tot++;
        if (mod_ctl) bad = 1'b1;
      end
    end
    check(!bad, "R7 low after swallow", int'(bad), 0);
    check(tot == 84, "R7 cycle length", tot, 84);
    start(1, 0, 5, "R7 A=0 setup");
    bad = mod_ctl;
    tot = 0;
    do begin
      @(negedge clk);
      tot++;
      if (mod_ctl) bad = 1'b1;
    end while (!div_out && tot < LIMIT);
    check(!bad, "R7 A=0 never high", int'(bad), 0);
  endtask

  task automatic t_midcycle();
    int n;
    start(0, 2, 10, "R6 setup");
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 5) set_cfg(2, 7, 20);
    end while (!div_out && n < LIMIT);
    check(n == 82, "R6 current cycle kept", n, 82);
    wait_pulse(n);
    check(n == 647, "R6 new cycle", n, 647);
  endtask

  task automatic cfg_case(int m, int a, int b, bit exp);
    @(negedge clk);
    set_cfg(m, a, b);
    @(negedge clk);
    check(cfg_ok == exp, "R8 cfg_ok", int'(cfg_ok), int'(exp));
  endtask

  task automatic t_cfg();
    cfg_case(0, 0, 7, 1'b1);
    cfg_case(0, 5, 6, 1'b0);
    cfg_case(0, 0, 2, 1'b0);
    cfg_case(0, 5, 4, 1'b0);
    cfg_case(3, 0, 63, 1'b1);
    cfg_case(3, 62, 62, 1'b0);
    cfg_case(3, 63, 8191, 1'b1);
    cfg_case(1, 16, 16, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_modes();
    t_a_edges();
    t_b_edges();
    t_swallow();
    t_midcycle();
    t_cfg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule